// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block collects up to sixteen asynchronous event lines and turns them into one interrupt request toward a processor. Each event line is brought into the clock domain, and a low-to-high transition on it marks that source as pending. A per-source enable mask decides which pending sources may drive the request line. Masking has no effect on what is pending, so a source that fired while masked raises the request as soon as it is enabled.

Software controls the block through a write-only register port: one address clears pending bits, two addresses clear and set enable bits, and one address loads the 8-bit vector code of a chosen source. When the processor answers the request with an acknowledge pulse, the block selects the lowest-numbered source that is pending and enabled. It drives that source's vector on an 8-bit bus with an output enable for the length of the pulse. At the end of the pulse it clears only that source, so any other pending sources keep the request asserted and are served by later acknowledges.

Top module: `vic_top`

## Requirements
- R1: A rising edge on source input n sets pending bit n at the third rising clock edge after the input goes high (two synchronizer stages and one edge-detect stage). If source n is enabled, irq_o rises at the next clock edge after that.
- R2: A write to address 0x1C clears every pending bit whose position is one in wr_data_i[15:0]. Pending bits written as zero keep their state.
- R3: A write to address 0x1D clears the enable bits selected by ones in wr_data_i[15:0]. A write to address 0x1E sets them. In both cases, enable bits written as zero are unchanged.
- R4: After reset, all sources are disabled, every vector is 8'h00, irq_o is 0, vec_oe_o is 0 and vec_o is 8'h00.
- R5: Changing an enable bit never changes the pending bit. A source that became pending while disabled drives irq_o high one cycle after it is enabled.
- R6: A write to address 0x1F stores wr_data_i[7:0] as the vector of the source numbered wr_data_i[11:8].
- R7: When several sources are pending and enabled, the lowest-numbered one wins the acknowledge.
- R8: vec_oe_o follows ack_i delayed by one clock. While it is high, vec_o holds the vector of the winner chosen at the clock edge where ack_i was first seen high. While it is low, vec_o is 8'h00.
- R9: At the clock edge where ack_i is first seen low after a pulse, only the winner's pending bit is cleared. The other pending bits stay set and keep irq_o asserted.
- R10: If a rising edge sets a pending bit at the same clock edge as a software or acknowledge clear of that bit, the bit ends up set.
- R11: irq_o is registered. It equals the OR over all sources of (pending AND enabled) as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 16 | Asynchronous event inputs, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 16 | Register write data |
| ack_i | input | 1 | Interrupt acknowledge pulse from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the acknowledged source |
| vec_oe_o | output | 1 | Vector bus output enable |

## Verification
The hardest case to reach is a clear that lands on the same clock edge as a new edge-detected event for the same bit. Software can only see the input pin, not the pending register. The stimulus uses the fixed three-edge capture latency from R1: it raises a source on a falling edge and schedules a clear write of that bit so the write strobe is sampled on the third following rising edge. It then checks through irq_o and a later acknowledge that the event survived. Priority order and single-bit clearing are checked by firing many sources at once under different masks and draining them with repeated acknowledges, comparing each returned vector with one computed from the source number.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  parameter int unsigned N_SRC  = 16;
  parameter int unsigned VEC_W  = 8;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADR_PEND_CLR = 5'h1C;
  localparam logic [ADDR_W-1:0] ADR_EN_CLR   = 5'h1D;
  localparam logic [ADDR_W-1:0] ADR_EN_SET   = 5'h1E;
  localparam logic [ADDR_W-1:0] ADR_VEC_LD   = 5'h1F;
endpackage

// File: rtl/vic_sync_edge.sv
`timescale 1ns/1ps
module vic_sync_edge #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[g] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/vic_prio_enc.sv
`timescale 1ns/1ps
module vic_prio_enc #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // scan downward so the lowest set bit is assigned last
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/vic_vec_table.sv
`timescale 1ns/1ps
module vic_vec_table #(
  parameter int unsigned N     = 16,
  parameter int unsigned VEC_W = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wsel_i,
  input  logic [VEC_W-1:0] wvec_i,
  input  logic [IDX_W-1:0] rsel_i,
  output logic [VEC_W-1:0] rvec_o
);
  logic [VEC_W-1:0] tab_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) tab_q[i] <= '0;
    end else if (we_i) begin
      tab_q[wsel_i] <= wvec_i;
    end
  end

  assign rvec_o = tab_q[rsel_i];
endmodule

// File: rtl/vic_top.sv
`timescale 1ns/1ps
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC_P  = vic_pkg::N_SRC,
  parameter int unsigned VEC_W_P  = vic_pkg::VEC_W,
  parameter int unsigned DATA_W_P = vic_pkg::DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_SRC_P-1:0]  src_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W_P-1:0] wr_data_i,
  input  logic                ack_i,
  output logic                irq_o,
  output logic [VEC_W_P-1:0]  vec_o,
  output logic                vec_oe_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC_P);

  logic [N_SRC_P-1:0] rise, pending_q, pending_d, en_q, active;
  logic [N_SRC_P-1:0] sw_clr, ack_clr;
  logic [IDX_W-1:0]   win_idx, win_q;
  logic               win_any, hit_q, ack_q, irq_q;
  logic [VEC_W_P-1:0] win_vec, vec_q;
  logic               wr_pclr, wr_eclr, wr_eset, wr_vec;
  logic               ack_rise, ack_fall;

  assign wr_pclr = wr_en_i && (wr_addr_i == ADR_PEND_CLR);
  assign wr_eclr = wr_en_i && (wr_addr_i == ADR_EN_CLR);
  assign wr_eset = wr_en_i && (wr_addr_i == ADR_EN_SET);
  assign wr_vec  = wr_en_i && (wr_addr_i == ADR_VEC_LD);

  vic_sync_edge #(.N(N_SRC_P)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(src_i),
    .rise_o (rise)
  );

  assign active = pending_q & en_q;

  vic_prio_enc #(.N(N_SRC_P), .IDX_W(IDX_W)) i_prio (
    .req_i(active),
    .idx_o(win_idx),
    .any_o(win_any)
  );

  vic_vec_table #(.N(N_SRC_P), .VEC_W(VEC_W_P), .IDX_W(IDX_W)) i_tab (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_vec),
    .wsel_i(wr_data_i[VEC_W_P +: IDX_W]),
    .wvec_i(wr_data_i[VEC_W_P-1:0]),
    .rsel_i(win_idx),
    .rvec_o(win_vec)
  );

  assign ack_rise = ack_i & ~ack_q;
  assign ack_fall = ~ack_i & ack_q;

  assign sw_clr = wr_pclr ? wr_data_i[N_SRC_P-1:0] : '0;

  always_comb begin
    ack_clr = '0;
    if (ack_fall && hit_q) ack_clr[win_q] = 1'b1;
  end

  // a fresh edge beats a coincident clear
  assign pending_d = (pending_q & ~(sw_clr | ack_clr)) | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= '0;
      en_q      <= '0;
      irq_q     <= 1'b0;
    end else begin
      pending_q <= pending_d;
      irq_q     <= |active;
      if (wr_eclr)      en_q <= en_q & ~wr_data_i[N_SRC_P-1:0];
      else if (wr_eset) en_q <= en_q |  wr_data_i[N_SRC_P-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      win_q <= '0;
      hit_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= ack_i;
      if (ack_rise) begin
        win_q <= win_idx;
        hit_q <= win_any;
        vec_q <= win_any ? win_vec : '0;
      end
    end
  end

  assign irq_o    = irq_q;
  assign vec_oe_o = ack_q;
  assign vec_o    = ack_q ? vec_q : '0;
endmodule

// File: rtl/vic_chk.sv
`timescale 1ns/1ps
module vic_chk
  import vic_pkg::*;
#(
  parameter int unsigned N     = 16,
  parameter int unsigned VEC_W = 8,
  parameter int unsigned DW    = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DW-1:0]     wr_data_i,
  input logic              ack_i,
  input logic              irq_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic              vec_oe_o,
  input logic [N-1:0]      pending_i,
  input logic [N-1:0]      en_i
);
  p_oe_follows_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_oe_o);
  p_oe_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !vec_oe_o);
  p_vec_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_oe_o && ack_i) |=> $stable(vec_o));
  p_irq_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pending_i & en_i)) |=> irq_o);
  p_irq_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(pending_i & en_i)) |=> !irq_o);
  p_mask_keeps_pend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == ADR_EN_CLR || wr_addr_i == ADR_EN_SET)
      && !(vec_oe_o && !ack_i))
    |=> (($past(pending_i) & ~pending_i) == '0));
  p_one_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == ADR_PEND_CLR)
    |=> ($countones($past(pending_i) & ~pending_i) <= 1));
  p_disable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADR_EN_CLR)
    |=> ((en_i & $past(wr_data_i[N-1:0])) == '0));
endmodule

bind vic_top vic_chk #(.N(N_SRC_P), .VEC_W(VEC_W_P), .DW(DATA_W_P)) i_vic_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .ack_i    (ack_i),
  .irq_o    (irq_o),
  .vec_o    (vec_o),
  .vec_oe_o (vec_oe_o),
  .pending_i(pending_q),
  .en_i     (en_q)
);

// File: tb/test_vic_top.sv
`timescale 1ns/1ps
module test_vic_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] src_i = '0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        ack_i = 1'b0;
  logic        irq_o;
  logic [7:0]  vec_o;
  logic        vec_oe_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  vic_top i_vic_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o), .vec_oe_o(vec_oe_o)
  );

  function automatic logic [7:0] vec_of(int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // returns after pending is set (3 edges) plus one edge for irq_o
  task automatic pulse(logic [15:0] m);
    @(negedge clk_i);
    src_i = src_i | m;
    repeat (3) @(negedge clk_i);
    src_i = src_i & ~m;
    @(negedge clk_i);
  endtask

  task automatic do_ack(output logic [7:0] v, output logic oe_in, output logic oe_after);
    @(negedge clk_i);
    ack_i = 1'b1;
    @(negedge clk_i);
    v = vec_o; oe_in = vec_oe_o;
    @(negedge clk_i);
    ack_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    oe_after = vec_oe_o;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic oe_in, oe_after;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R4 irq", 16'(irq_o), 16'h0);
    chk("R4 oe", 16'(vec_oe_o), 16'h0);
    chk("R4 vec", 16'(vec_o), 16'h0);

    // masked event, later enabled; vector still at reset value
    pulse(16'h0008);
    repeat (3) @(negedge clk_i);
    chk("R4 masked irq", 16'(irq_o), 16'h0);
    wr(5'h1E, 16'h0008);
    @(negedge clk_i);
    chk("R5 enable raises irq", 16'(irq_o), 16'h1);
    do_ack(v, oe_in, oe_after);
    chk("R4 vector reset zero", 16'(v), 16'h0);
    chk("R8 oe during ack", 16'(oe_in), 16'h1);
    chk("R8 oe after ack", 16'(oe_after), 16'h0);
    chk("R8 vec zero idle", 16'(vec_o), 16'h0);
    chk("R9 irq cleared", 16'(irq_o), 16'h0);

    for (int i = 0; i < 16; i++) wr(5'h1F, 16'((i << 8) | vec_of(i)));
    wr(5'h1E, 16'hFFFF);

    // single-source sweep
    for (int i = 0; i < 16; i++) begin
      pulse(16'(1 << i));
      chk($sformatf("R1 irq src%0d", i), 16'(irq_o), 16'h1);
      do_ack(v, oe_in, oe_after);
      chk($sformatf("R6 vec src%0d", i), 16'(v), 16'(vec_of(i)));
      chk("R8 oe", 16'(oe_in), 16'h1);
      chk("R9 irq after", 16'(irq_o), 16'h0);
    end

    // priority under mask: odd sources disabled
    wr(5'h1D, 16'hAAAA);
    pulse(16'hFFFF);
    chk("R3 irq with even enabled", 16'(irq_o), 16'h1);
    for (int k = 0; k < 8; k++) begin
      do_ack(v, oe_in, oe_after);
      chk($sformatf("R7 even order %0d", k), 16'(v), 16'(vec_of(2 * k)));
    end
    chk("R9 irq drained even", 16'(irq_o), 16'h0);
    wr(5'h1E, 16'hAAAA);
    @(negedge clk_i);
    chk("R5 odd pending kept", 16'(irq_o), 16'h1);
    for (int k = 0; k < 8; k++) begin
      do_ack(v, oe_in, oe_after);
      chk($sformatf("R7 odd order %0d", k), 16'(v), 16'(vec_of(2 * k + 1)));
    end
    chk("R9 irq drained odd", 16'(irq_o), 16'h0);

    // software clear
    pulse(16'h00F0);
    wr(5'h1C, 16'h0030);
    @(negedge clk_i);
    chk("R2 irq others left", 16'(irq_o), 16'h1);
    do_ack(v, oe_in, oe_after);
    chk("R2 first left", 16'(v), 16'(vec_of(6)));
    do_ack(v, oe_in, oe_after);
    chk("R2 second left", 16'(v), 16'(vec_of(7)));
    chk("R2 irq drained", 16'(irq_o), 16'h0);

    // set wins over coincident clear: write strobe sampled on third edge
    @(negedge clk_i);
    src_i = 16'h0200;
    @(negedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'h1C; wr_data_i = 16'h0200;
    @(negedge clk_i);
    wr_en_i = 1'b0; src_i = '0;
    @(negedge clk_i);
    chk("R10 set wins irq", 16'(irq_o), 16'h1);
    do_ack(v, oe_in, oe_after);
    chk("R10 set wins vec", 16'(v), 16'(vec_of(9)));

    // zero bits leave mask alone
    wr(5'h1D, 16'h0000);
    pulse(16'h0004);
    chk("R3 zero disable no effect", 16'(irq_o), 16'h1);
    wr(5'h1D, 16'h0004);
    @(negedge clk_i);
    chk("R11 irq follows mask", 16'(irq_o), 16'h0);
    wr(5'h1E, 16'h0004);
    @(negedge clk_i);
    chk("R5 pending survived mask", 16'(irq_o), 16'h1);
    do_ack(v, oe_in, oe_after);
    chk("R6 vec src2", 16'(v), 16'(vec_of(2)));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule